// File: doc/BRIEF.md
# Dual-Scan Colour STN Line Formatter

This block turns a stream of RGB pixels into the drive signals of a dual-scan colour STN panel. The panel is split into an upper and a lower half of equal height, and the two halves are scanned together. Each input beat carries a group of pixels for the upper half and the matching group for the lower half of the current line pair. The block packs three subpixel bits per pixel into a continuous bit stream and emits that stream a byte at a time on two 8-bit ports. A pixel's components can therefore cross from one byte into the next.

Each byte is held for one shift period of two clocks, with the shift clock high in the second clock. After the last byte of a line pair comes a line pulse two clocks wide, during which nothing is shifted. Blanking of a parameter length follows the pulse. The frame pulse rides on the line pulse that closes the first line pair of every frame. If the input runs dry in the middle of a line, the shift clock and display enable simply wait. Stale bits are never sent.

The default build serves a 640-pixel-wide panel with two 240-line halves and accepts eight pixels per half in each beat.

Top module: `stn_dual_fmt`

## Requirements
- R1: While reset is high and in the first clock after it, `sclk`, `lpulse`, `fpulse` and `den` are low and `in_ready` is high.
- R2: Beat encoding: pixel i of a beat sits in `in_up[3i+2:3i]` with R at bit 3i+2, G at 3i+1 and B at 3i, and lower i comes first on the line. On `up_data` the subpixels of the upper half go out in the order R, G, B of pixel 1, then pixel 2, and so on. The first subpixel of a line is on bit 7 of its first byte, and the stream continues with no gap from bit 0 of one byte to bit 7 of the next.
- R3: `lo_data` carries the lower-half line that pairs with the upper line, using the same packing and in the same shift periods as `up_data`.
- R4: Each byte is held for two clocks with `sclk` high only in the second. Each line pair gets exactly PIXELS*3/8 shift-clock pulses.
- R5: After the last byte of a line pair, `lpulse` is high for exactly two clocks. During that time `sclk` and `den` stay low.
- R6: `fpulse` is high only together with `lpulse`, and only on the pulse that ends line pair 0. The line-pair count wraps after LINES_HALF pairs.
- R7: When input data is already waiting, exactly HBLANK clocks pass between the fall of `lpulse` and the first byte of the next line pair.
- R8: If input data runs out in the middle of a line, `sclk` and `den` stay low until the next beat arrives. No byte is dropped or repeated. When the input keeps pace, no pause occurs.
- R9: `den` is high exactly in the clocks in which a valid byte is on the data ports. At all other times both data ports read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat in this clock |
| in_up | input | 3*PIX_PER_BEAT | Upper-half pixels of the beat, RGB per pixel |
| in_lo | input | 3*PIX_PER_BEAT | Lower-half pixels of the beat, RGB per pixel |
| up_data | output | 8 | Upper-half panel data byte |
| lo_data | output | 8 | Lower-half panel data byte |
| sclk | output | 1 | Shift clock, one pulse per byte |
| lpulse | output | 1 | Line pulse after each line pair |
| fpulse | output | 1 | Frame pulse, first line pair of a frame |
| den | output | 1 | Display enable while valid bytes are shifted |

## Verification
The bench drives a small build with 16 pixels and 3 line pairs, so one 24-bit beat spans three bytes and pixels cross byte borders. It checks every byte of three frames against a bit stream it computes itself. If the bits were placed per byte rather than packed continuously, or the halves were swapped, those comparisons fail. Every other line is starved for input part-way through. A design that shifted stale data would then emit extra bytes, and one that failed to pause would show no gap in its enable. The bench also counts the width of the line pulse, the blanking gap, and the line pair on which the frame pulse appears. An off-by-one in the line counter's wrap or the blanking counter shows up directly in those counts.

// File: rtl/stn_fmt_pkg.sv
package stn_fmt_pkg;

    // subpixel bits per pixel and clocks per line pulse
    localparam int SUB_PER_PX = 3;
    localparam int PULSE_CLKS = 2;

    typedef enum logic [1:0] {
        PH_SHIFT = 2'd0,
        PH_PULSE = 2'd1,
        PH_BLANK = 2'd2
    } line_phase_e;

    typedef struct packed {
        logic [7:0] up;
        logic [7:0] lo;
    } byte_pair_t;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/stn_beat_pack.sv
module stn_beat_pack #(
    parameter int PIX_PER_BEAT = 8
) (
    input  logic [3*PIX_PER_BEAT-1:0] px,
    output logic [3*PIX_PER_BEAT-1:0] word
);
    localparam int W = stn_fmt_pkg::SUB_PER_PX * PIX_PER_BEAT;

    // first pixel lands at the top of the word, R above G above B
    for (genvar i = 0; i < PIX_PER_BEAT; i++) begin : g_px
        assign word[W-1-3*i -: 3] = px[3*i +: 3];
    end
endmodule

// File: rtl/stn_beat_buf.sv
module stn_beat_buf
    import stn_fmt_pkg::*;
#(
    parameter int PIX_PER_BEAT = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [3*PIX_PER_BEAT-1:0] word_up,
    input  logic [3*PIX_PER_BEAT-1:0] word_lo,
    input  logic                      take,
    output logic                      have,
    output logic                      at_last,
    output byte_pair_t                cur
);
    localparam int W  = SUB_PER_PX * PIX_PER_BEAT;
    localparam int NB = W / 8;
    localparam int IW = cnt_width(NB);

    logic [W-1:0]  held_up, held_lo;
    logic [IW-1:0] idx;

    assign at_last = (idx == IW'(NB - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            have    <= 1'b0;
            idx     <= '0;
            held_up <= '0;
            held_lo <= '0;
        end else if (load) begin
            have    <= 1'b1;
            idx     <= '0;
            held_up <= word_up;
            held_lo <= word_lo;
        end else if (take) begin
            if (at_last) have <= 1'b0;
            else         idx  <= idx + 1'b1;
        end
    end

    always_comb begin
        cur.up = held_up[(W-1) - 8*int'(idx) -: 8];
        cur.lo = held_lo[(W-1) - 8*int'(idx) -: 8];
    end
endmodule

// File: rtl/stn_line_timer.sv
module stn_line_timer
    import stn_fmt_pkg::*;
#(
    parameter int BYTES_PER_LINE = 240,
    parameter int LINES_HALF     = 240,
    parameter int HBLANK         = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic have,
    output logic show,
    output logic take,
    output logic sclk,
    output logic lpulse,
    output logic fpulse
);
    localparam int BW = cnt_width(BYTES_PER_LINE);
    localparam int LW = cnt_width(LINES_HALF);
    localparam int CW = cnt_width((HBLANK > PULSE_CLKS) ? HBLANK : PULSE_CLKS);

    line_phase_e   phase;
    logic          half_b;      // second clock of a shift period
    logic [BW-1:0] byte_no;
    logic [LW-1:0] pair_no;
    logic [CW-1:0] tick;

    always_comb begin
        show   = (phase == PH_SHIFT) && (half_b || have);
        sclk   = (phase == PH_SHIFT) && half_b;
        take   = sclk;
        lpulse = (phase == PH_PULSE);
        fpulse = lpulse && (pair_no == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_SHIFT;
            half_b  <= 1'b0;
            byte_no <= '0;
            pair_no <= '0;
            tick    <= '0;
        end else begin
            unique case (phase)
                PH_SHIFT: begin
                    if (!half_b) begin
                        if (have) half_b <= 1'b1;
                    end else begin
                        half_b <= 1'b0;
                        if (byte_no == BW'(BYTES_PER_LINE - 1)) begin
                            byte_no <= '0;
                            tick    <= '0;
                            phase   <= PH_PULSE;
                        end else begin
                            byte_no <= byte_no + 1'b1;
                        end
                    end
                end
                PH_PULSE: begin
                    if (tick == CW'(PULSE_CLKS - 1)) begin
                        tick  <= '0;
                        phase <= PH_BLANK;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                PH_BLANK: begin
                    if (tick == CW'(HBLANK - 1)) begin
                        tick    <= '0;
                        phase   <= PH_SHIFT;
                        pair_no <= (pair_no == LW'(LINES_HALF - 1)) ? '0 : pair_no + 1'b1;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: phase <= PH_SHIFT;
            endcase
        end
    end
endmodule

// File: rtl/stn_dual_fmt.sv
module stn_dual_fmt
    import stn_fmt_pkg::*;
#(
    parameter int PIXELS       = 640,
    parameter int LINES_HALF   = 240,
    parameter int PIX_PER_BEAT = 8,
    parameter int HBLANK       = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [3*PIX_PER_BEAT-1:0] in_up,
    input  logic [3*PIX_PER_BEAT-1:0] in_lo,
    output logic [7:0]                up_data,
    output logic [7:0]                lo_data,
    output logic                      sclk,
    output logic                      lpulse,
    output logic                      fpulse,
    output logic                      den
);
    localparam int BEAT_W         = SUB_PER_PX * PIX_PER_BEAT;
    localparam int BYTES_PER_LINE = PIXELS * SUB_PER_PX / 8;

    logic [BEAT_W-1:0] word_up, word_lo;
    logic              have, at_last, take, show, load;
    byte_pair_t        cur;

    stn_beat_pack #(.PIX_PER_BEAT(PIX_PER_BEAT)) i_pack_up (.px(in_up), .word(word_up));
    stn_beat_pack #(.PIX_PER_BEAT(PIX_PER_BEAT)) i_pack_lo (.px(in_lo), .word(word_lo));

    assign in_ready = !have || (take && at_last);
    assign load     = in_valid && in_ready;

    stn_beat_buf #(.PIX_PER_BEAT(PIX_PER_BEAT)) i_buf (
        .clk(clk), .rst(rst), .load(load),
        .word_up(word_up), .word_lo(word_lo),
        .take(take), .have(have), .at_last(at_last), .cur(cur)
    );

    stn_line_timer #(
        .BYTES_PER_LINE(BYTES_PER_LINE),
        .LINES_HALF(LINES_HALF),
        .HBLANK(HBLANK)
    ) i_timer (
        .clk(clk), .rst(rst), .have(have),
        .show(show), .take(take), .sclk(sclk),
        .lpulse(lpulse), .fpulse(fpulse)
    );

    assign den     = show;
    assign up_data = show ? cur.up : 8'h00;
    assign lo_data = show ? cur.lo : 8'h00;
endmodule

// File: rtl/stn_dual_fmt_chk.sv
module stn_dual_fmt_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] up_data,
    input logic [7:0] lo_data,
    input logic       sclk,
    input logic       lpulse,
    input logic       fpulse,
    input logic       den
);
    assert_sclk_with_den_R9: assert property (@(posedge clk) disable iff (rst)
        sclk |-> den);
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !den |-> (up_data == 8'h00 && lo_data == 8'h00));
    assert_sclk_single_R4: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk);
    assert_byte_held_R4: assert property (@(posedge clk) disable iff (rst)
        sclk |-> ($stable(up_data) && $stable(lo_data)));
    assert_pulse_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        lpulse |-> (!den && !sclk));
    assert_pulse_min_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(lpulse) |=> lpulse);
    assert_pulse_max_R5: assert property (@(posedge clk) disable iff (rst)
        (lpulse && $past(lpulse)) |=> !lpulse);
    assert_frame_in_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        fpulse |-> lpulse);
endmodule

bind stn_dual_fmt stn_dual_fmt_chk i_chk (
    .clk(clk), .rst(rst), .up_data(up_data), .lo_data(lo_data),
    .sclk(sclk), .lpulse(lpulse), .fpulse(fpulse), .den(den)
);

// File: tb/test_stn_dual_fmt.sv
module test_stn_dual_fmt;
    localparam int PX  = 16;
    localparam int LH  = 3;
    localparam int PPB = 8;
    localparam int HB  = 3;
    localparam int NF  = 3;
    localparam int BPL = PX * 3 / 8;
    localparam int BEATS = PX / PPB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [3*PPB-1:0] in_up = '0, in_lo = '0;
    logic [7:0] up_data, lo_data;
    logic sclk, lpulse, fpulse, den;

    int total = 0, bad = 0;
    bit mon_on = 1'b0, finished = 1'b0;

    always #4 clk = ~clk;

    stn_dual_fmt #(.PIXELS(PX), .LINES_HALF(LH), .PIX_PER_BEAT(PPB), .HBLANK(HB)) i_stn_dual_fmt (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_up(in_up), .in_lo(in_lo), .up_data(up_data), .lo_data(lo_data),
        .sclk(sclk), .lpulse(lpulse), .fpulse(fpulse), .den(den)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] pix(input int f, input int l, input int p, input int h);
        int v;
        v = f * 37 + l * 11 + p * 5 + h * 3 + p * p;
        return 3'(v % 8);
    endfunction

    function automatic logic [7:0] exp_byte(input int f, input int l, input int h, input int b);
        logic [7:0] r;
        logic [2:0] v;
        for (int k = 0; k < 8; k++) begin
            int s;
            s = 8 * b + k;
            v = pix(f, l, s / 3, h);
            r[7-k] = v[2 - (s % 3)];
        end
        return r;
    endfunction

    function automatic bit stall_line(input int f, input int l);
        return ((f + l) % 2) == 0;
    endfunction

    // monitor state
    bit prev_sclk = 0, prev_lp = 0, gap_on = 0, paused = 0;
    int bcnt = 0, mline = 0, mframe = 0, pairs = 0, lp_len = 0, gap = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (sclk && !prev_sclk) begin
                chk(up_data == exp_byte(mframe, mline, 0, bcnt), "R2 upper byte", up_data, exp_byte(mframe, mline, 0, bcnt));
                chk(lo_data == exp_byte(mframe, mline, 1, bcnt), "R3 lower byte", lo_data, exp_byte(mframe, mline, 1, bcnt));
                chk(den && !lpulse, "R9 den during shift", den, 1);
                bcnt++;
            end
            if (!den && bcnt >= 1 && bcnt < BPL) begin
                paused = 1;
                if (sclk) chk(0, "R8 sclk while paused", sclk, 0);
            end
            if (den && gap_on) begin
                chk(gap == HB, "R7 blank length", gap, HB);
                gap_on = 0;
            end else if (!den && gap_on) gap++;
            if (lpulse && !prev_lp) begin
                chk(bcnt == BPL, "R4 pulses per line", bcnt, BPL);
                chk(fpulse == (mline == 0), "R6 frame pulse", fpulse, mline == 0);
                chk(paused == stall_line(mframe, mline), "R8 pause matches starvation", paused, stall_line(mframe, mline));
                bcnt = 0; paused = 0; lp_len = 1;
                pairs++;
                mline++;
                if (mline == LH) begin mline = 0; mframe++; end
            end else if (lpulse) begin
                lp_len++;
                if (fpulse != (mline == 1 || (mline == 0 && LH == 1)))
                    chk(0, "R6 frame pulse held", fpulse, !fpulse);
            end else if (prev_lp) begin
                chk(lp_len == 2, "R5 line pulse width", lp_len, 2);
                gap_on = 1; gap = 1;
            end
            if (!lpulse && fpulse) chk(0, "R6 frame pulse outside line pulse", fpulse, 0);
            prev_sclk = sclk;
            prev_lp = lpulse;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!sclk && !lpulse && !fpulse && !den, "R1 outputs low in reset", {sclk, lpulse, fpulse, den}, 0);
        chk(in_ready, "R1 ready in reset", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(!sclk && !lpulse && !fpulse && !den, "R1 outputs low after reset", {sclk, lpulse, fpulse, den}, 0);
        chk(in_ready, "R1 ready after reset", in_ready, 1);
        mon_on = 1'b1;
        for (int f = 0; f < NF; f++) begin
            for (int l = 0; l < LH; l++) begin
                for (int bt = 0; bt < BEATS; bt++) begin
                    if (bt == 1 && stall_line(f, l)) begin
                        in_valid = 1'b0;
                        repeat (20) @(negedge clk);
                    end
                    for (int i = 0; i < PPB; i++) begin
                        in_up[3*i +: 3] = pix(f, l, bt * PPB + i, 0);
                        in_lo[3*i +: 3] = pix(f, l, bt * PPB + i, 1);
                    end
                    in_valid = 1'b1;
                    while (!in_ready) @(negedge clk);
                    @(negedge clk);
                end
            end
        end
        in_valid = 1'b0;
        while (pairs < NF * LH) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(pairs == NF * LH, "R6 line pair count", pairs, NF * LH);
        chk(!den && up_data == 8'h00 && lo_data == 8'h00, "R9 idle ports zero", up_data, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", pairs, NF * LH);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule